// File: doc/BRIEF.md
# Card Host Controller Register Window

This block is the software-facing front of a memory-card host controller. It decodes a 4 KB word-addressed window and holds the control settings that the command and data engines consume: power and clock settings, command argument and command word, data timeout, transfer length and data control. It also collects the events those engines report into a status word and exposes that status to software. The engines attach through plain internal ports: event pulses, live FIFO flags, response words, a remaining byte count, FIFO head data and one-cycle strobes.

The status word has two halves. Bits 0 to 10 are sticky event flags. An engine pulse sets them, and software writes ones to a clear location to drop them. Bits 11 to 21 are live FIFO and activity flags that the data engine drives directly. Two interrupt lines each OR together the status bits that their own mask enables. The FIFO data port answers at every word address from 0x80 to 0xBC, and a block of identification bytes sits at the top of the window.

Bus accesses are single-cycle strobes. A read returns its data from a register one cycle later, and that register holds its value until the next read.

Top module: `mmc_host_regs`

## Requirements
- R1: After reset every readable register reads zero, the stored masks are zero and both interrupt lines are low.
- R2: Writes to power (0x00), clock (0x04) and data control (0x2C) keep only bits 7:0. Writes to data length (0x28) keep only bits 15:0. All other bits read back as zero.
- R3: Argument (0x08) and data timer (0x24) keep all 32 bits. The masks at 0x3C (line 0) and 0x40 (line 1) keep bits 21:0. Argument is also driven on `cmd_arg_o`.
- R4: A write to command (0x0C) stores bits 10:0 with bit 10 forced to zero. When written bit 10 is one, `cmd_go_o` is high during the write cycle. When it is zero, `cmd_go_o` stays low.
- R5: A write to data control with bit 0 set raises `data_start_o` during the write cycle. Bit 0 clear leaves it low.
- R6: An `evt_set_i` pulse on bit b sets status bit b (b in 0..10), and the bit stays set until cleared. If a set and a clear of the same bit fall in the same cycle, the bit ends up set.
- R7: A write to clear (0x38) drops exactly those status bits 0..10 whose written bit is one. The other sticky bits are untouched.
- R8: Status (0x34) reads {`live_stat_i` in bits 21:11, sticky flags in bits 10:0}. Writing clear never changes bits 21:11.
- R9: `irq_o[k]` is high exactly when (status AND mask k) is nonzero. It follows mask writes, events, clears and `live_stat_i` within the same cycle as the register change.
- R10: A read at any word 0x80..0xBC returns `fifo_rdata_i` and pulses `fifo_pop_o` for that cycle. A write there pulses `fifo_push_o` with `fifo_wdata_o` equal to the written word. Addresses 0x7C and 0xC0 do neither.
- R11: Reads of word i (i = 0..7) from 0xFE0 return the bytes 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order.
- R12: 0x10 returns `resp_cmd_i`. 0x14 + 4k returns `resp_words_i` bits [32k+31:32k]. 0x30 returns `data_cnt_i`. 0x48 returns (`data_cnt_i` + 3) / 4.
- R13: Reads of unmapped words (for example 0x44, 0x4C, 0x7C, 0x100) return zero. Writes there change no register.
- R14: `bus_rdata_o` changes only on the clock edge that ends a read cycle. It holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Single-cycle write strobe |
| bus_rd_i | input | 1 | Single-cycle read strobe |
| bus_addr_i | input | 12 | Byte address within the window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| evt_set_i | input | 11 | Sticky event set pulses, bits 0..10 |
| live_stat_i | input | 11 | Live flags shown as status bits 21..11 |
| resp_cmd_i | input | 6 | Index of the last response |
| resp_words_i | input | 128 | Four response words, word 0 in the low bits |
| data_cnt_i | input | 16 | Remaining transfer byte count |
| fifo_rdata_i | input | 32 | Word at the FIFO head |
| power_o | output | 8 | Power setting |
| clk_ctrl_o | output | 8 | Card clock setting |
| cmd_arg_o | output | 32 | Command argument |
| cmd_o | output | 11 | Stored command word |
| cmd_go_o | output | 1 | Command launch strobe |
| data_timer_o | output | 32 | Data timeout setting |
| data_len_o | output | 16 | Transfer length |
| data_ctrl_o | output | 8 | Data control setting |
| data_start_o | output | 1 | Data transfer launch strobe |
| fifo_push_o | output | 1 | FIFO write strobe |
| fifo_wdata_o | output | 32 | FIFO write word |
| fifo_pop_o | output | 1 | FIFO read strobe |
| irq_o | output | 2 | Masked interrupt lines |

## Verification
The bench targets the cycle in which an event and a clear of the same flag collide. A design that lets the clear win loses that event. A clear of all ones is written while the live flags are high. A clear that reached the upper bits would hide FIFO state that software still needs. The alias edges of the FIFO port (0x80, 0xBC and the neighbours 0x7C, 0xC0) are exercised, where an off-by-one decode pops a word on the wrong read. Random mask, event, clear and live-flag traffic is compared against a model of both interrupt lines, which catches a line wired to the wrong mask or a mask truncated below bit 21.

// File: rtl/mmch_pkg.sv
package mmch_pkg;

    localparam int ADDR_W     = 12;
    localparam int WORD_W     = ADDR_W - 2;
    localparam int DATA_W     = 32;
    localparam int LATCH_W    = 11;
    localparam int LIVE_W     = 11;
    localparam int STAT_W     = LATCH_W + LIVE_W;
    localparam int CMD_W      = 11;
    localparam int CMD_GO_BIT = 10;
    localparam int DSTART_BIT = 0;
    localparam int NARROW_W   = 8;
    localparam int LEN_W      = 16;
    localparam int CNT_W      = 16;
    localparam int RESP_WORDS = 4;
    localparam int RESP_CMD_W = 6;
    localparam int IRQ_LINES  = 2;

    // word addresses (byte address / 4)
    localparam logic [WORD_W-1:0] W_POWER   = 10'h000;
    localparam logic [WORD_W-1:0] W_CLOCK   = 10'h001;
    localparam logic [WORD_W-1:0] W_ARG     = 10'h002;
    localparam logic [WORD_W-1:0] W_CMD     = 10'h003;
    localparam logic [WORD_W-1:0] W_RESPCMD = 10'h004;
    localparam logic [WORD_W-1:0] W_RESP0   = 10'h005;
    localparam logic [WORD_W-1:0] W_DTIMER  = 10'h009;
    localparam logic [WORD_W-1:0] W_DLEN    = 10'h00A;
    localparam logic [WORD_W-1:0] W_DCTRL   = 10'h00B;
    localparam logic [WORD_W-1:0] W_DCNT    = 10'h00C;
    localparam logic [WORD_W-1:0] W_STATUS  = 10'h00D;
    localparam logic [WORD_W-1:0] W_CLEAR   = 10'h00E;
    localparam logic [WORD_W-1:0] W_MASK0   = 10'h00F;
    localparam logic [WORD_W-1:0] W_FIFOCNT = 10'h012;

    // FIFO data port: words 0x20..0x2F (bytes 0x80..0xBC)
    function automatic logic is_fifo_word(input logic [WORD_W-1:0] w);
        return w[WORD_W-1:4] == 6'h02;
    endfunction

    // identification block: words 0x3F8..0x3FF (bytes 0xFE0..0xFFC)
    function automatic logic is_id_word(input logic [WORD_W-1:0] w);
        return &w[WORD_W-1:3];
    endfunction

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'h81;
            3'd1:    return 8'h11;
            3'd2:    return 8'h04;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/mmch_bank.sv
module mmch_bank
    import mmch_pkg::*;
#(
    parameter int NUM_IRQ = IRQ_LINES
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic [WORD_W-1:0]         word_i,
    input  logic [DATA_W-1:0]         wdata_i,
    input  logic [LATCH_W-1:0]        evt_i,
    output logic [NARROW_W-1:0]       power_o,
    output logic [NARROW_W-1:0]       clock_o,
    output logic [DATA_W-1:0]         arg_o,
    output logic [CMD_W-1:0]          cmd_o,
    output logic [DATA_W-1:0]         dtimer_o,
    output logic [LEN_W-1:0]          dlen_o,
    output logic [NARROW_W-1:0]       dctrl_o,
    output logic [LATCH_W-1:0]        latched_o,
    output logic [NUM_IRQ*STAT_W-1:0] mask_o,
    output logic                      cmd_go_o,
    output logic                      data_start_o,
    output logic                      fifo_push_o
);

    typedef struct packed {
        logic [NARROW_W-1:0]             power;
        logic [NARROW_W-1:0]             clock;
        logic [DATA_W-1:0]               arg;
        logic [CMD_W-1:0]                cmd;
        logic [DATA_W-1:0]               dtimer;
        logic [LEN_W-1:0]                dlen;
        logic [NARROW_W-1:0]             dctrl;
        logic [LATCH_W-1:0]              lat;
        logic [NUM_IRQ-1:0][STAT_W-1:0]  mask;
    } bank_t;

    bank_t               bank_d, bank_q;
    logic [LATCH_W-1:0]  clr_d;

    always_comb begin
        bank_d       = bank_q;
        clr_d        = '0;
        cmd_go_o     = 1'b0;
        data_start_o = 1'b0;
        fifo_push_o  = 1'b0;
        if (wr_en_i) begin
            if (is_fifo_word(word_i)) begin
                fifo_push_o = 1'b1;
            end else begin
                case (word_i)
                    W_POWER:  bank_d.power  = wdata_i[NARROW_W-1:0];
                    W_CLOCK:  bank_d.clock  = wdata_i[NARROW_W-1:0];
                    W_ARG:    bank_d.arg    = wdata_i;
                    W_CMD: begin
                        bank_d.cmd             = wdata_i[CMD_W-1:0];
                        bank_d.cmd[CMD_GO_BIT] = 1'b0;
                        cmd_go_o               = wdata_i[CMD_GO_BIT];
                    end
                    W_DTIMER: bank_d.dtimer = wdata_i;
                    W_DLEN:   bank_d.dlen   = wdata_i[LEN_W-1:0];
                    W_DCTRL: begin
                        bank_d.dctrl = wdata_i[NARROW_W-1:0];
                        data_start_o = wdata_i[DSTART_BIT];
                    end
                    W_CLEAR:  clr_d = wdata_i[LATCH_W-1:0];
                    default: ;
                endcase
                for (int k = 0; k < NUM_IRQ; k++) begin
                    if (word_i == WORD_W'(int'(W_MASK0) + k)) begin
                        bank_d.mask[k] = wdata_i[STAT_W-1:0];
                    end
                end
            end
        end
        // a new event outranks a clear landing in the same cycle
        bank_d.lat = (bank_q.lat & ~clr_d) | evt_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign power_o   = bank_q.power;
    assign clock_o   = bank_q.clock;
    assign arg_o     = bank_q.arg;
    assign cmd_o     = bank_q.cmd;
    assign dtimer_o  = bank_q.dtimer;
    assign dlen_o    = bank_q.dlen;
    assign dctrl_o   = bank_q.dctrl;
    assign latched_o = bank_q.lat;
    assign mask_o    = bank_q.mask;

endmodule

// File: rtl/mmch_rdmux.sv
module mmch_rdmux
    import mmch_pkg::*;
#(
    parameter int NUM_IRQ = IRQ_LINES
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en_i,
    input  logic [WORD_W-1:0]            word_i,
    input  logic [NARROW_W-1:0]          power_i,
    input  logic [NARROW_W-1:0]          clock_i,
    input  logic [DATA_W-1:0]            arg_i,
    input  logic [CMD_W-1:0]             cmd_i,
    input  logic [DATA_W-1:0]            dtimer_i,
    input  logic [LEN_W-1:0]             dlen_i,
    input  logic [NARROW_W-1:0]          dctrl_i,
    input  logic [STAT_W-1:0]            status_i,
    input  logic [NUM_IRQ*STAT_W-1:0]    mask_i,
    input  logic [RESP_CMD_W-1:0]        resp_cmd_i,
    input  logic [RESP_WORDS*DATA_W-1:0] resp_i,
    input  logic [CNT_W-1:0]             dcnt_i,
    input  logic [DATA_W-1:0]            fifo_rdata_i,
    output logic [DATA_W-1:0]            rdata_o,
    output logic                         fifo_pop_o
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_t;

    rd_t               rd_d, rd_q;
    logic [DATA_W-1:0] sel_d;
    logic [CNT_W:0]    cnt_round_d;

    always_comb begin
        cnt_round_d = {1'b0, dcnt_i} + (CNT_W+1)'(3);
        sel_d       = '0;
        fifo_pop_o  = 1'b0;
        if (is_id_word(word_i)) begin
            sel_d = DATA_W'(id_byte(word_i[2:0]));
        end else if (is_fifo_word(word_i)) begin
            sel_d      = fifo_rdata_i;
            fifo_pop_o = rd_en_i;
        end else begin
            case (word_i)
                W_POWER:   sel_d = DATA_W'(power_i);
                W_CLOCK:   sel_d = DATA_W'(clock_i);
                W_ARG:     sel_d = arg_i;
                W_CMD:     sel_d = DATA_W'(cmd_i);
                W_RESPCMD: sel_d = DATA_W'(resp_cmd_i);
                W_DTIMER:  sel_d = dtimer_i;
                W_DLEN:    sel_d = DATA_W'(dlen_i);
                W_DCTRL:   sel_d = DATA_W'(dctrl_i);
                W_DCNT:    sel_d = DATA_W'(dcnt_i);
                W_STATUS:  sel_d = DATA_W'(status_i);
                W_FIFOCNT: sel_d = DATA_W'(cnt_round_d[CNT_W:2]);
                default: ;
            endcase
            for (int k = 0; k < RESP_WORDS; k++) begin
                if (word_i == WORD_W'(int'(W_RESP0) + k)) begin
                    sel_d = resp_i[k*DATA_W +: DATA_W];
                end
            end
            for (int k = 0; k < NUM_IRQ; k++) begin
                if (word_i == WORD_W'(int'(W_MASK0) + k)) begin
                    sel_d = DATA_W'(mask_i[k*STAT_W +: STAT_W]);
                end
            end
        end
        rd_d.rdata = rd_en_i ? sel_d : rd_q.rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata_o = rd_q.rdata;

endmodule

// File: rtl/mmch_irq.sv
module mmch_irq
    import mmch_pkg::*;
#(
    parameter int NUM_IRQ = IRQ_LINES
) (
    input  logic [STAT_W-1:0]         status_i,
    input  logic [NUM_IRQ*STAT_W-1:0] mask_i,
    output logic [NUM_IRQ-1:0]        irq_o
);

    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line
        assign irq_o[k] = |(status_i & mask_i[k*STAT_W +: STAT_W]);
    end

endmodule

// File: rtl/mmc_host_regs.sv
module mmc_host_regs
    import mmch_pkg::*;
#(
    parameter int NUM_IRQ = IRQ_LINES
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_wr_i,
    input  logic                         bus_rd_i,
    input  logic [ADDR_W-1:0]            bus_addr_i,
    input  logic [DATA_W-1:0]            bus_wdata_i,
    output logic [DATA_W-1:0]            bus_rdata_o,
    input  logic [LATCH_W-1:0]           evt_set_i,
    input  logic [LIVE_W-1:0]            live_stat_i,
    input  logic [RESP_CMD_W-1:0]        resp_cmd_i,
    input  logic [RESP_WORDS*DATA_W-1:0] resp_words_i,
    input  logic [CNT_W-1:0]             data_cnt_i,
    input  logic [DATA_W-1:0]            fifo_rdata_i,
    output logic [NARROW_W-1:0]          power_o,
    output logic [NARROW_W-1:0]          clk_ctrl_o,
    output logic [DATA_W-1:0]            cmd_arg_o,
    output logic [CMD_W-1:0]             cmd_o,
    output logic                         cmd_go_o,
    output logic [DATA_W-1:0]            data_timer_o,
    output logic [LEN_W-1:0]             data_len_o,
    output logic [NARROW_W-1:0]          data_ctrl_o,
    output logic                         data_start_o,
    output logic                         fifo_push_o,
    output logic [DATA_W-1:0]            fifo_wdata_o,
    output logic                         fifo_pop_o,
    output logic [NUM_IRQ-1:0]           irq_o
);

    logic [WORD_W-1:0]         word;
    logic                      unused_lsb;
    logic [LATCH_W-1:0]        latched;
    logic [STAT_W-1:0]         status;
    logic [NUM_IRQ*STAT_W-1:0] mask_flat;

    assign word         = bus_addr_i[ADDR_W-1:2];
    assign unused_lsb   = ^bus_addr_i[1:0];
    assign status       = {live_stat_i, latched};
    assign fifo_wdata_o = bus_wdata_i;

    mmch_bank #(.NUM_IRQ(NUM_IRQ)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (bus_wr_i),
        .word_i       (word),
        .wdata_i      (bus_wdata_i),
        .evt_i        (evt_set_i),
        .power_o      (power_o),
        .clock_o      (clk_ctrl_o),
        .arg_o        (cmd_arg_o),
        .cmd_o        (cmd_o),
        .dtimer_o     (data_timer_o),
        .dlen_o       (data_len_o),
        .dctrl_o      (data_ctrl_o),
        .latched_o    (latched),
        .mask_o       (mask_flat),
        .cmd_go_o     (cmd_go_o),
        .data_start_o (data_start_o),
        .fifo_push_o  (fifo_push_o)
    );

    mmch_rdmux #(.NUM_IRQ(NUM_IRQ)) u_rdmux (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_en_i      (bus_rd_i),
        .word_i       (word),
        .power_i      (power_o),
        .clock_i      (clk_ctrl_o),
        .arg_i        (cmd_arg_o),
        .cmd_i        (cmd_o),
        .dtimer_i     (data_timer_o),
        .dlen_i       (data_len_o),
        .dctrl_i      (data_ctrl_o),
        .status_i     (status),
        .mask_i       (mask_flat),
        .resp_cmd_i   (resp_cmd_i),
        .resp_i       (resp_words_i),
        .dcnt_i       (data_cnt_i),
        .fifo_rdata_i (fifo_rdata_i),
        .rdata_o      (bus_rdata_o),
        .fifo_pop_o   (fifo_pop_o)
    );

    mmch_irq #(.NUM_IRQ(NUM_IRQ)) u_irq (
        .status_i (status),
        .mask_i   (mask_flat),
        .irq_o    (irq_o)
    );

endmodule

// File: rtl/mmc_host_regs_chk.sv
module mmc_host_regs_chk
    import mmch_pkg::*;
#(
    parameter int NUM_IRQ = IRQ_LINES
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_wr_i,
    input logic                      bus_rd_i,
    input logic [ADDR_W-1:0]         bus_addr_i,
    input logic [DATA_W-1:0]         bus_wdata_i,
    input logic [DATA_W-1:0]         bus_rdata_o,
    input logic [LATCH_W-1:0]        evt_set_i,
    input logic [LATCH_W-1:0]        latched,
    input logic [NUM_IRQ*STAT_W-1:0] mask_flat,
    input logic [NARROW_W-1:0]       power_o,
    input logic [DATA_W-1:0]         cmd_arg_o,
    input logic [CMD_W-1:0]          cmd_o,
    input logic                      cmd_go_o,
    input logic                      fifo_pop_o,
    input logic [NUM_IRQ-1:0]        irq_o
);

    AST_NARROW_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == 12'h000) |=> (power_o == $past(bus_wdata_i[NARROW_W-1:0]))); // R2

    AST_ARG_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == 12'h008) |=> (cmd_arg_o == $past(bus_wdata_i))); // R3

    AST_CMD_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go_o |=> (cmd_o == ($past(bus_wdata_i[CMD_W-1:0]) & 11'h3FF))); // R4

    AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set_i != '0) |=> ((latched & $past(evt_set_i)) == $past(evt_set_i))); // R6

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == 12'h038 && evt_set_i == '0)
        |=> ((latched & $past(bus_wdata_i[LATCH_W-1:0])) == '0)); // R7

    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq_chk
        AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_flat[k*STAT_W +: STAT_W] == '0) |-> !irq_o[k]); // R9
    end

    AST_POP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop_o |-> bus_rd_i); // R10

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_i |=> $stable(bus_rdata_o)); // R14

endmodule

bind mmc_host_regs mmc_host_regs_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .evt_set_i   (evt_set_i),
    .latched     (latched),
    .mask_flat   (mask_flat),
    .power_o     (power_o),
    .cmd_arg_o   (cmd_arg_o),
    .cmd_o       (cmd_o),
    .cmd_go_o    (cmd_go_o),
    .fifo_pop_o  (fifo_pop_o),
    .irq_o       (irq_o)
);

// File: tb/mmc_host_regs_bench.sv
`timescale 1ns/1ps
module mmc_host_regs_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr_i = 1'b0, bus_rd_i = 1'b0;
    logic [11:0]  bus_addr_i = '0;
    logic [31:0]  bus_wdata_i = '0;
    logic [31:0]  bus_rdata_o;
    logic [10:0]  evt_set_i = '0, live_stat_i = '0;
    logic [5:0]   resp_cmd_i = '0;
    logic [127:0] resp_words_i = '0;
    logic [15:0]  data_cnt_i = '0;
    logic [31:0]  fifo_rdata_i = '0;
    logic [7:0]   power_o, clk_ctrl_o, data_ctrl_o;
    logic [31:0]  cmd_arg_o, data_timer_o, fifo_wdata_o;
    logic [10:0]  cmd_o;
    logic [15:0]  data_len_o;
    logic         cmd_go_o, data_start_o, fifo_push_o, fifo_pop_o;
    logic [1:0]   irq_o;

    int nchk = 0, nfail = 0;
    logic [10:0] m_lat = '0;
    logic [21:0] m_mask [2] = '{default: '0};

    always #2.5 clk = ~clk;

    mmc_host_regs u_mmc_host_regs (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bwr(input logic [11:0] a, input logic [31:0] d);
        bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_wr_i = 1'b0;
    endtask

    task automatic brd(input logic [11:0] a, output logic [31:0] d);
        bus_rd_i = 1'b1; bus_addr_i = a;
        @(negedge clk);
        bus_rd_i = 1'b0;
        d = bus_rdata_o;
    endtask

    task automatic pulse_evt(input logic [10:0] e);
        evt_set_i = e;
        @(negedge clk);
        evt_set_i = '0;
        m_lat = m_lat | e;
    endtask

    function automatic logic exp_irq(input int k);
        return |({live_stat_i, m_lat} & m_mask[k]);
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        logic [7:0]  ids [8] = '{8'h81, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", 32'(irq_o), 0);
        for (int a = 0; a <= 'h48; a += 4) begin
            brd(12'(a), r);
            chk("R1 reg", r, 0);
        end

        // R2 truncation
        bwr(12'h000, 32'hFFFF_FFA5); brd(12'h000, r); chk("R2 power", r, 32'hA5);
        bwr(12'h004, 32'h1234_5678); brd(12'h004, r); chk("R2 clock", r, 32'h78);
        chk("R2 clk_ctrl_o", 32'(clk_ctrl_o), 32'h78);
        bwr(12'h02C, 32'hABCD_EF02); brd(12'h02C, r); chk("R2 dctrl", r, 32'h02);
        bwr(12'h028, 32'hDEAD_BEEF); brd(12'h028, r); chk("R2 dlen", r, 32'hBEEF);

        // R3 full width
        bwr(12'h008, 32'hCAFE_F00D); brd(12'h008, r); chk("R3 arg", r, 32'hCAFE_F00D);
        chk("R3 cmd_arg_o", cmd_arg_o, 32'hCAFE_F00D);
        bwr(12'h024, 32'h0BAD_F00D); brd(12'h024, r); chk("R3 dtimer", r, 32'h0BAD_F00D);

        // R4 command: go strobe in write cycle, bit 10 not stored
        bus_wr_i = 1'b1; bus_addr_i = 12'h00C; bus_wdata_i = 32'hFFFF_F4C5;
        #1 chk("R4 go high", 32'(cmd_go_o), 1);
        @(negedge clk); bus_wr_i = 1'b0;
        brd(12'h00C, r); chk("R4 cmd stored", r, 32'h0C5);
        bus_wr_i = 1'b1; bus_addr_i = 12'h00C; bus_wdata_i = 32'h0000_0285;
        #1 chk("R4 go low", 32'(cmd_go_o), 0);
        @(negedge clk); bus_wr_i = 1'b0;
        chk("R4 cmd_o", 32'(cmd_o), 32'h285);

        // R5 data start strobe
        bus_wr_i = 1'b1; bus_addr_i = 12'h02C; bus_wdata_i = 32'h0000_0103;
        #1 chk("R5 start high", 32'(data_start_o), 1);
        @(negedge clk); bus_wr_i = 1'b0;
        chk("R5 dctrl", 32'(data_ctrl_o), 32'h03);
        bus_wr_i = 1'b1; bus_addr_i = 12'h02C; bus_wdata_i = 32'h0000_0002;
        #1 chk("R5 start low", 32'(data_start_o), 0);
        @(negedge clk); bus_wr_i = 1'b0;

        // R6 latch and set-beats-clear
        pulse_evt(11'h401);
        brd(12'h034, r); chk("R6 latched", r, 32'h401);
        evt_set_i = 11'h008; bus_wr_i = 1'b1; bus_addr_i = 12'h038; bus_wdata_i = 32'h7FF;
        @(negedge clk);
        evt_set_i = '0; bus_wr_i = 1'b0; m_lat = 11'h008;
        brd(12'h034, r); chk("R6 set wins", r, 32'h008);

        // R7 selective clear
        pulse_evt(11'h0F0);
        bwr(12'h038, 32'h0000_0030); m_lat = m_lat & ~11'h030;
        brd(12'h034, r); chk("R7 selective clear", r, 32'(m_lat));

        // R8 live bits unaffected by clear
        live_stat_i = 11'h7FF;
        bwr(12'h038, 32'hFFFF_FFFF); m_lat = '0;
        brd(12'h034, r); chk("R8 live kept", r, 32'h003F_F800);
        live_stat_i = 11'h155;
        brd(12'h034, r); chk("R8 live follows", r, {10'h0, 11'h155, 11'h0});

        // R10 FIFO alias
        fifo_rdata_i = 32'h1122_3344;
        foreach (ids[i]) begin end
        for (int a = 'h80; a <= 'hBC; a += 'h3C) begin
            bus_rd_i = 1'b1; bus_addr_i = 12'(a);
            #1 chk("R10 pop", 32'(fifo_pop_o), 1);
            @(negedge clk); bus_rd_i = 1'b0;
            chk("R10 fifo read", bus_rdata_o, 32'h1122_3344);
        end
        bus_rd_i = 1'b1; bus_addr_i = 12'h07C;
        #1 chk("R10 no pop 0x7C", 32'(fifo_pop_o), 0);
        @(negedge clk);
        bus_addr_i = 12'h0C0;
        #1 chk("R10 no pop 0xC0", 32'(fifo_pop_o), 0);
        @(negedge clk); bus_rd_i = 1'b0;
        bus_wr_i = 1'b1; bus_addr_i = 12'h0A4; bus_wdata_i = 32'h5566_7788;
        #1 chk("R10 push", 32'(fifo_push_o), 1);
        chk("R10 push data", fifo_wdata_o, 32'h5566_7788);
        @(negedge clk); bus_wr_i = 1'b0;

        // R11 identification bytes
        for (int i = 0; i < 8; i++) begin
            brd(12'(12'hFE0 + 4 * i), r);
            chk("R11 id", r, 32'(ids[i]));
        end

        // R12 engine values
        resp_cmd_i = 6'h2A;
        resp_words_i = {32'hD0D0_0003, 32'hC0C0_0002, 32'hB0B0_0001, 32'hA0A0_0000};
        brd(12'h010, r); chk("R12 respcmd", r, 32'h2A);
        for (int k = 0; k < 4; k++) begin
            brd(12'(12'h014 + 4 * k), r);
            chk("R12 resp", r, resp_words_i[k*32 +: 32]);
        end
        data_cnt_i = 16'd5;  brd(12'h030, r); chk("R12 dcnt", r, 5);
        brd(12'h048, r); chk("R12 fifocnt 5", r, 2);
        data_cnt_i = 16'd8;  brd(12'h048, r); chk("R12 fifocnt 8", r, 2);
        data_cnt_i = 16'hFFFF; brd(12'h048, r); chk("R12 fifocnt max", r, 32'h4000);
        data_cnt_i = 16'd0;  brd(12'h048, r); chk("R12 fifocnt 0", r, 0);

        // R13 unmapped
        bwr(12'h044, 32'hFFFF_FFFF);
        bwr(12'h100, 32'hFFFF_FFFF);
        brd(12'h03C, r); chk("R13 mask0 untouched", r, 0);
        brd(12'h040, r); chk("R13 mask1 untouched", r, 0);
        brd(12'h000, r); chk("R13 power untouched", r, 32'hA5);
        brd(12'h044, r); chk("R13 read 0x44", r, 0);
        brd(12'h04C, r); chk("R13 read 0x4C", r, 0);
        brd(12'h100, r); chk("R13 read 0x100", r, 0);

        // R14 hold without read
        brd(12'h000, r);
        pulse_evt(11'h002);
        bwr(12'h000, 32'h0000_0011);
        chk("R14 hold", bus_rdata_o, 32'hA5);

        // R9 random traffic against irq model
        for (int it = 0; it < 300; it++) begin
            int op;
            op = $urandom_range(0, 3);
            case (op)
                0: begin
                    int k;
                    logic [31:0] v;
                    k = $urandom_range(0, 1);
                    v = $urandom & $urandom;
                    bwr(12'(12'h03C + 4 * k), v);
                    m_mask[k] = v[21:0];
                    brd(12'(12'h03C + 4 * k), r);
                    chk("R3 mask", r, {10'h0, v[21:0]});
                end
                1: pulse_evt(11'($urandom & $urandom));
                2: begin
                    logic [31:0] v;
                    v = $urandom;
                    bwr(12'h038, v);
                    m_lat = m_lat & ~v[10:0];
                end
                default: begin
                    live_stat_i = 11'($urandom & $urandom & $urandom);
                    @(negedge clk);
                end
            endcase
            chk("R9 irq0", 32'(irq_o[0]), 32'(exp_irq(0)));
            chk("R9 irq1", 32'(irq_o[1]), 32'(exp_irq(1)));
            brd(12'h034, r);
            chk("R8 status", r, {10'h0, live_stat_i, m_lat});
        end

        finish_run();
    end

endmodule